// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a 4096-byte serial memory. It watches the clock and data lines of a two-wire I2C bus using a fast system clock. It recognises bus start, repeated start and stop events, and checks the device address, including a variant that a strap input selects. For writes it collects a two-byte memory address. Each data byte is then handed, with its target address, to a separate page buffer. A commit pulse follows at the closing stop.

For reads it fetches bytes through a combinational read port and shifts them out MSB first. The data line is driven only as an open-drain pull-down enable, both for acknowledge bits and for read data. A busy input from the write machinery makes the block refuse its own address, so a master can poll until the write cycle is over. One internal byte pointer serves both directions:

- During writes it wraps within a 32-byte page.
- During reads it wraps across the whole memory.

Top module: `i2cee_slave`

## Requirements
- R1: The device address byte is accepted when its upper seven bits equal 1010 followed by 100 when `strapAlt` is 1, or 000 when it is 0. Bit 0 of that byte selects read (1) or write (0). An accepted address is acknowledged by pulling SDA low during the ninth clock.
- R2: After a non-matching device address the block does not acknowledge that byte or any later byte, produces no write handoff, and leaves its pointer unchanged until the next START.
- R3: While `wrBusy` is 1 when the device address byte completes, the address is not acknowledged, even if it matches.
- R4: A falling SDA with SCL high is a START, and a rising SDA with SCL high is a STOP. SDA is sampled on SCL rising edges. The block changes `sdaOe` only while SCL is low. After reset `sdaOe` is 0.
- R5: In a write, the two bytes after the device address form the memory address: first the high byte, then the low byte. Bits 15 to 12 are ignored. Both bytes are acknowledged.
- R6: Each data byte of a write is acknowledged and handed out as a single-cycle `wrValid` pulse, with `wrAddr` equal to the pointer and `wrData` equal to the byte.
- R7: After each write handoff only the low five pointer bits increment, wrapping from 31 to 0 within the 32-byte page.
- R8: `wrCommit` pulses for one cycle after a STOP when at least one data byte was handed out since the last START. A repeated START or an address-only write produces no commit.
- R9: A read with no preceding address phase returns bytes starting at the current pointer. The pointer is 0 after reset.
- R10: A write-mode address phase followed by a repeated START and a read returns data starting at the loaded address.
- R11: During a read, each master ACK makes the block send the next byte. The pointer increments after every byte sent and wraps from 0xFFF to 0x000.
- R12: A master NACK ends the output. SDA stays released for any further clocks until START or STOP.
- R13: A START in the middle of a byte discards the partial byte and restarts bit counting, so a complete address byte that follows is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | When 1, pull the data line low |
| strapAlt | input | 1 | Selects the alternate device address variant |
| wrBusy | input | 1 | Internal write cycle in progress |
| rdAddr | output | 12 | Current byte pointer, used as the read address |
| rdData | input | 8 | Byte stored at `rdAddr` |
| wrValid | output | 1 | One-cycle strobe: a write byte is handed out |
| wrAddr | output | 12 | Target address of the handed-out byte |
| wrData | output | 8 | Handed-out write byte |
| wrCommit | output | 1 | One-cycle strobe: start the write cycle |

## Verification
The write handoff and the in-page pointer wrap land on the same clock edge. The edge that presents the last byte of a page also folds the pointer back to the page start. This is provoked by page writes that begin a few bytes before a page boundary, both directed and at random start addresses. It is judged by comparing each handed-out address with a bench-computed page-wrapped sequence. Read-back of the written bytes then confirms that nothing spilled into the next page.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WDAT, ST_READ, ST_WAIT
  } ctlState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ackSet;   // drive ACK in the coming acknowledge slot
    logic hiCap;    // capture high address byte
    logic ptrLoad;  // load pointer from high byte + received byte
    logic wrByte;   // hand out received byte, step pointer in page
    logic txLoad;   // load transmit byte from memory, step pointer
    logic txOff;    // stop transmitting
  } ctlStrobe_t;
endpackage

// File: rtl/i2cee_dp.sv
module i2cee_dp
  import i2cee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  ctlStrobe_t        strobe,
  input  logic [7:0]        rdData,
  output logic              startEv,
  output logic              stopEv,
  output logic              byteDone,
  output logic              ackEnd,
  output logic              mAck,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] ptr,
  output logic              sdaOe
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [SYNC_N-1:0] sclSy, sdaSy;
  logic sclS, sdaS, sclP, sdaP;
  logic sclRise, sclFall;
  logic [3:0] bitCnt;
  logic ackPhase, ackDrive, txMode;
  logic [7:0] shiftReg, txReg;
  logic [HI_W-1:0] hiReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSy <= '1;
      sdaSy <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSy <= {sclSy[SYNC_N-2:0], sclIn};
      sdaSy <= {sdaSy[SYNC_N-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign sclS    = sclSy[SYNC_N-1];
  assign sdaS    = sdaSy[SYNC_N-1];
  assign sclRise = sclS & ~sclP;
  assign sclFall = ~sclS & sclP;
  assign startEv = sclS & sclP & sdaP & ~sdaS;
  assign stopEv  = sclS & sclP & ~sdaP & sdaS;
  assign ackEnd  = sclFall & ackPhase;
  assign rxByte  = shiftReg;

  // Bit engine: receive shifting, acknowledge slot, transmit shifting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
      txMode   <= 1'b0;
      shiftReg <= '0;
      txReg    <= '0;
      byteDone <= 1'b0;
      mAck     <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (startEv || stopEv) begin
        bitCnt   <= '0;
        ackPhase <= 1'b0;
        ackDrive <= 1'b0;
        txMode   <= 1'b0;
      end else begin
        if (strobe.ackSet) ackDrive <= 1'b1;
        if (sclRise && !ackPhase && bitCnt < BYTE_BITS) begin
          shiftReg <= {shiftReg[6:0], sdaS};
          bitCnt   <= bitCnt + 4'd1;
          byteDone <= (bitCnt == BYTE_BITS - 4'd1);
        end
        if (sclFall && !ackPhase) begin
          if (bitCnt == BYTE_BITS) ackPhase <= 1'b1;
          else if (bitCnt != 4'd0 && txMode) txReg <= {txReg[6:0], 1'b0};
        end
        if (sclRise && ackPhase) mAck <= ~sdaS;
        if (ackEnd) begin
          ackPhase <= 1'b0;
          bitCnt   <= '0;
          ackDrive <= 1'b0;
        end
        if (strobe.txLoad) begin
          txReg  <= rdData;
          txMode <= 1'b1;
        end
        if (strobe.txOff) txMode <= 1'b0;
      end
    end
  end

  // Byte pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= '0;
      ptr   <= '0;
    end else begin
      if (strobe.hiCap)   hiReg <= rxByte[HI_W-1:0];
      if (strobe.ptrLoad) ptr <= {hiReg, rxByte};
      if (strobe.wrByte)  ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_ONE};
      if (strobe.txLoad)  ptr <= ptr + ADDR_ONE;
    end
  end

  assign sdaOe = ackPhase ? ackDrive : (txMode & ~txReg[7]);
endmodule

// File: rtl/i2cee_ctrl.sv
module i2cee_ctrl
  import i2cee_pkg::*;
#(
  parameter logic [3:0] DEV_TAG = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       byteDone,
  input  logic       ackEnd,
  input  logic       mAck,
  input  logic [7:0] rxByte,
  input  logic       strapAlt,
  input  logic       wrBusy,
  output ctlStrobe_t strobe,
  output logic       wrCommit
);
  ctlState_t state, nextState;
  logic loadPend, wrote, commitNow, devHit;

  assign devHit = (rxByte[7:1] == {DEV_TAG, strapAlt, 2'b00}) && !wrBusy;

  always_comb begin
    nextState = state;
    strobe    = '0;
    commitNow = 1'b0;
    if (startEv) begin
      nextState = ST_DEV;
    end else if (stopEv) begin
      nextState = ST_IDLE;
      commitNow = wrote;
    end else begin
      case (state)
        ST_DEV: if (byteDone) begin
          if (devHit) begin
            strobe.ackSet = 1'b1;
            nextState = rxByte[0] ? ST_READ : ST_AHI;
          end else begin
            nextState = ST_WAIT;
          end
        end
        ST_AHI: if (byteDone) begin
          strobe.hiCap  = 1'b1;
          strobe.ackSet = 1'b1;
          nextState = ST_ALO;
        end
        ST_ALO: if (byteDone) begin
          strobe.ptrLoad = 1'b1;
          strobe.ackSet  = 1'b1;
          nextState = ST_WDAT;
        end
        ST_WDAT: if (byteDone) begin
          strobe.wrByte = 1'b1;
          strobe.ackSet = 1'b1;
        end
        ST_READ: if (ackEnd) begin
          if (loadPend || mAck) begin
            strobe.txLoad = 1'b1;
          end else begin
            strobe.txOff = 1'b1;
            nextState = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      loadPend <= 1'b0;
      wrote    <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      state    <= nextState;
      wrCommit <= commitNow;
      if (startEv || stopEv) begin
        loadPend <= 1'b0;
        wrote    <= 1'b0;
      end else begin
        if (state == ST_DEV && byteDone && devHit && rxByte[0]) loadPend <= 1'b1;
        else if (state == ST_READ && ackEnd) loadPend <= 1'b0;
        if (strobe.wrByte) wrote <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
  import i2cee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int SYNC_N = 2,
  parameter logic [3:0] DEV_TAG = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  input  logic              strapAlt,
  input  logic              wrBusy,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        rdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);
  ctlStrobe_t strobe;
  logic startEv, stopEv, byteDone, ackEnd, mAck;
  logic [7:0] rxByte;
  logic [ADDR_W-1:0] ptr;

  i2cee_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_N(SYNC_N)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strobe(strobe),
    .rdData(rdData), .startEv(startEv), .stopEv(stopEv), .byteDone(byteDone),
    .ackEnd(ackEnd), .mAck(mAck), .rxByte(rxByte), .ptr(ptr), .sdaOe(sdaOe)
  );

  i2cee_ctrl #(.DEV_TAG(DEV_TAG)) uCtrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .byteDone(byteDone), .ackEnd(ackEnd), .mAck(mAck), .rxByte(rxByte),
    .strapAlt(strapAlt), .wrBusy(wrBusy), .strobe(strobe), .wrCommit(wrCommit)
  );

  assign rdAddr  = ptr;
  assign wrAddr  = ptr;
  assign wrData  = rxByte;
  assign wrValid = strobe.wrByte;
endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk #(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int SYNC_N = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaOe,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrCommit
);
  localparam logic [PAGE_W-1:0] PAGE_ONE = 1;
  logic [SYNC_N-1:0] sclChk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclChk <= '1;
    else       sclChk <= {sclChk[SYNC_N-2:0], sclIn};
  end

  // R4: the pull-down enable moves only while the (synchronised) clock is low
  a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclChk[SYNC_N-1]);

  // R6: each handoff is a single-cycle strobe
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  // R7: pointer after a handoff is the next address within the same page
  a_r7_page_wrap: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> (rdAddr == {$past(wrAddr[ADDR_W-1:PAGE_W]),
                            $past(wrAddr[PAGE_W-1:0]) + PAGE_ONE}));

  // R8: commit is a single pulse and never overlaps a handoff
  a_r8_commit_single: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);
  a_r8_commit_apart: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |-> !wrValid);
endmodule

bind i2cee_slave i2cee_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_N(SYNC_N)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .wrValid(wrValid),
  .wrAddr(wrAddr), .rdAddr(rdAddr), .wrCommit(wrCommit)
);

// File: tb/tb_i2cee_slave.sv
module tb_i2cee_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 5;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic masterLow = 1'b0;
  logic strapAlt = 1'b0;
  logic wrBusy = 1'b0;
  logic sdaOe, wrValid, wrCommit;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [7:0] rdData, wrData;
  logic sdaLine;

  logic [7:0] memArr [4096];
  logic [AW-1:0] logA [64];
  logic [7:0] logD [64];
  int logN = 0;
  int commitCnt = 0;
  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  logic [7:0] txData [8];
  logic [7:0] rxData [8];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = ~(masterLow | sdaOe);
  assign rdData = memArr[rdAddr];

  i2cee_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(scl), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .strapAlt(strapAlt), .wrBusy(wrBusy), .rdAddr(rdAddr), .rdData(rdData),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrCommit(wrCommit)
  );

  always @(posedge clk) begin
    if (wrValid) begin
      memArr[wrAddr] <= wrData;
      if (logN < 64) begin
        logA[logN] <= wrAddr;
        logD[logN] <= wrData;
      end
      logN <= logN + 1;
    end
    if (wrCommit) commitCnt <= commitCnt + 1;
  end

  function automatic logic [7:0] devByte(input logic alt, input logic rw);
    return {4'b1010, alt, 2'b00, rw};
  endfunction

  function automatic logic [AW-1:0] pageStep(input logic [AW-1:0] base, input int i);
    logic [4:0] lo;
    lo = base[4:0] + 5'(i);
    return {base[AW-1:5], lo};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    masterLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    masterLow = 1'b1; waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    masterLow = 1'b1; waitQ();
    scl = 1'b1; waitQ();
    masterLow = 1'b0; waitQ();
    waitQ();
  endtask

  task automatic sendBit(input logic b);
    masterLow = ~b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    masterLow = 1'b0; waitQ();
    scl = 1'b1; waitQ();
    acked = ~sdaLine;
    waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] b);
    logic early;
    masterLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      scl = 1'b1; waitQ();
      early = sdaLine;
      waitQ();
      b[i] = sdaLine;
      check(early == b[i], "R4 data stable while SCL high", int'(b[i]), int'(early));
      scl = 1'b0;
    end
    waitQ();
    masterLow = giveAck; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
    masterLow = 1'b0;
  endtask

  // write-mode address phase (no stop)
  task automatic addrPhase(input logic [15:0] a, input string tag);
    logic ak;
    busStart();
    sendByte(devByte(strapAlt, 1'b0), ak);
    check(ak, {tag, " R1 device ack"}, int'(ak), 1);
    sendByte(a[15:8], ak);
    check(ak, {tag, " R5 high byte ack"}, int'(ak), 1);
    sendByte(a[7:0], ak);
    check(ak, {tag, " R5 low byte ack"}, int'(ak), 1);
  endtask

  task automatic writeTxn(input logic [15:0] a, input int n, input string tag);
    logic ak;
    int n0, c0;
    n0 = logN; c0 = commitCnt;
    addrPhase(a, tag);
    for (int i = 0; i < n; i++) begin
      sendByte(txData[i], ak);
      check(ak, {tag, " R6 data ack"}, int'(ak), 1);
    end
    busStop();
    check(logN - n0 == n, {tag, " R6 handoff count"}, logN - n0, n);
    for (int i = 0; i < n; i++) begin
      if (n0 + i < 64) begin
        check(logA[n0+i] == pageStep(a[AW-1:0], i), {tag, " R7 R5 handoff address"},
              int'(logA[n0+i]), int'(pageStep(a[AW-1:0], i)));
        check(logD[n0+i] == txData[i], {tag, " R6 handoff data"},
              int'(logD[n0+i]), int'(txData[i]));
      end
    end
    check(commitCnt - c0 == 1, {tag, " R8 commit after stop"}, commitCnt - c0, 1);
  endtask

  // read n bytes after the device address (read mode); start already issued
  task automatic readBody(input int n, input logic lastAck);
    logic ak;
    sendByte(devByte(strapAlt, 1'b1), ak);
    check(ak, "R1 read address ack", int'(ak), 1);
    for (int i = 0; i < n; i++) recvByte((i < n - 1) ? 1'b1 : lastAck, rxData[i]);
  endtask

  task automatic selRead(input logic [15:0] a, input int n, input string tag);
    addrPhase(a, tag);
    busStart();
    readBody(n, 1'b0);
    busStop();
  endtask

  task automatic curRead(input int n);
    busStart();
    readBody(n, 1'b0);
    busStop();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    finish();
  end

  initial begin
    logic ak;
    logic [7:0] b;
    int n0, c0;
    logic [AW-1:0] expP;
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 4096; i++) memArr[i] = 8'(i ^ (i >> 4) ^ 8'h3C);

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sdaOe == 1'b0, "R4 reset sdaOe", int'(sdaOe), 0);
    check(wrValid == 1'b0 && wrCommit == 1'b0, "R6 R8 reset strobes", int'(wrValid), 0);
    check(rdAddr == 0, "R9 reset pointer", int'(rdAddr), 0);

    // R9: immediate read after reset starts at address 0
    curRead(2);
    check(rxData[0] == memArr[0], "R9 immediate read addr0", int'(rxData[0]), int'(memArr[0]));
    check(rxData[1] == memArr[1], "R11 sequential addr1", int'(rxData[1]), int'(memArr[1]));

    // R5: top nibble ignored
    txData[0] = 8'h5A;
    writeTxn(16'hF123, 1, "byte write");

    // R10/R11 selective + sequential read
    selRead(16'h0123, 4, "sel read");
    check(rxData[0] == 8'h5A, "R10 selective read data", int'(rxData[0]), 'h5A);
    for (int i = 1; i < 4; i++)
      check(rxData[i] == memArr[12'h123 + i], "R11 sequential data",
            int'(rxData[i]), int'(memArr[12'h123 + i]));

    // R9: immediate read continues from pointer
    curRead(2);
    check(rxData[0] == memArr[12'h127], "R9 continue pointer", int'(rxData[0]), int'(memArr[12'h127]));
    check(rxData[1] == memArr[12'h128], "R9 continue pointer+1", int'(rxData[1]), int'(memArr[12'h128]));

    // R7: page wrap during write (coincident handoff and wrap)
    for (int i = 0; i < 4; i++) txData[i] = 8'hA0 + 8'(i);
    writeTxn(16'h003E, 4, "page wrap");
    selRead(16'h0020, 2, "page readback");
    check(rxData[0] == 8'hA2 && rxData[1] == 8'hA3, "R7 wrapped bytes at page start",
          int'({rxData[0], rxData[1]}), 'hA2A3);
    check(memArr[12'h040] != 8'hA2, "R7 no spill to next page", int'(memArr[12'h040]), 0);

    // R11: read wrap at end of memory
    selRead(16'h0FFF, 3, "end wrap");
    check(rxData[0] == memArr[12'hFFF], "R11 last address", int'(rxData[0]), int'(memArr[12'hFFF]));
    check(rxData[1] == memArr[0], "R11 wrap to 0", int'(rxData[1]), int'(memArr[0]));
    check(rxData[2] == memArr[1], "R11 wrap to 1", int'(rxData[2]), int'(memArr[1]));

    // R2: non-matching address is ignored
    n0 = logN;
    busStart();
    sendByte(devByte(1'b1, 1'b0), ak);
    check(!ak, "R2 wrong address nack", int'(ak), 0);
    sendByte(8'h00, ak);
    check(!ak, "R2 later byte nack", int'(ak), 0);
    sendByte(8'h55, ak);
    sendByte(8'h77, ak);
    busStop();
    check(logN == n0, "R2 no handoff", logN - n0, 0);
    curRead(1);
    check(rxData[0] == memArr[2], "R2 pointer unchanged", int'(rxData[0]), int'(memArr[2]));

    // R1: strap selects variant
    strapAlt = 1'b1;
    txData[0] = 8'hC3;
    writeTxn(16'h0200, 1, "strap alt");
    busStart();
    sendByte(devByte(1'b0, 1'b0), ak);
    check(!ak, "R1 base variant rejected when strapped", int'(ak), 0);
    busStop();
    strapAlt = 1'b0;

    // R3: busy refuses address, then accepts
    wrBusy = 1'b1;
    busStart();
    sendByte(devByte(1'b0, 1'b0), ak);
    check(!ak, "R3 busy nack", int'(ak), 0);
    busStop();
    wrBusy = 1'b0;
    c0 = commitCnt;
    busStart();
    sendByte(devByte(1'b0, 1'b0), ak);
    check(ak, "R3 ack after busy clears", int'(ak), 1);
    busStop();
    check(commitCnt == c0, "R8 address-only no commit", commitCnt - c0, 0);

    // R8: repeated start after data cancels commit; read from next address
    c0 = commitCnt;
    addrPhase(16'h0300, "rs write");
    sendByte(8'h99, ak);
    busStart();
    readBody(1, 1'b0);
    busStop();
    check(commitCnt == c0, "R8 repeated start no commit", commitCnt - c0, 0);
    check(rxData[0] == memArr[12'h301], "R10 read after data", int'(rxData[0]), int'(memArr[12'h301]));

    // R13: start mid-byte aborts
    busStart();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    busStart();
    sendByte(devByte(1'b0, 1'b1), ak);
    check(ak, "R13 address after abort", int'(ak), 1);
    recvByte(1'b0, b);
    busStop();
    check(b == memArr[12'h302], "R13 read after abort", int'(b), int'(memArr[12'h302]));

    // R12: after master nack the line stays released
    busStart();
    readBody(1, 1'b0);
    recvByte(1'b0, b);
    check(b == 8'hFF, "R12 released after nack", int'(b), 'hFF);
    busStop();

    // Random writes with read-back
    for (int it = 0; it < 14; it++) begin
      int n;
      logic [15:0] a;
      n = 1 + int'($urandom % 4);
      a = 16'($urandom);
      for (int i = 0; i < n; i++) txData[i] = 8'($urandom);
      writeTxn(a, n, "random");
      selRead({4'h0, a[11:0]}, n, "random rb");
      expP = a[AW-1:0];
      for (int i = 0; i < n; i++) begin
        if (int'(expP[4:0]) + n <= 32 || i == 0)
          check(rxData[i] == txData[i], "R10 R6 random readback", int'(rxData[i]), int'(txData[i]));
      end
    end

    finish();
  end
endmodule